// File: doc/BRIEF.md
# Set/Clear Aliased Control Register Bank

This block is a small bank of 8-bit control registers on a simple byte-addressed bus. The bus has a write strobe, a read strobe, an 8-bit address and 8-bit write data. Each control register appears at three adjacent addresses:

- the lowest address replaces the register value;
- the next address ORs the write data into it;
- the third address clears every bit that is 1 in the write data.

After each of these operations the result is cut down to that register's writable bits.

Two further registers are plain masked registers:

- a power request register;
- a clock request register.

The bank also holds:

- four read-only identification bytes;
- a one-bit read-only status that chooses, in priority order, between the power request, the clock request and a suspend bit in the function control register.

A master reaches the bank through a serial-to-parallel bridge that is not part of this block. Reads are registered: the data comes out one cycle after the read strobe. An access to an address the bank does not decode raises a one-cycle error pulse.

Top module: `alias_ctl_bank`

## Requirements
- R1: A write to the base address of an aliased register loads the write data, masked, into that register.
- R2: A write to base+1 ORs the write data into the register, and the result is then masked.
- R3: A write to base+2 clears the register bits that are set in the write data, and the result is then masked.
- R4: Each aliased register has its own writable mask, applied after every operation:
  - function control (base 0x04): 0x80;
  - interface control (base 0x07): 0x61;
  - state-machine control (base 0xA1): 0x3F;
  - power control (base 0xAC): 0x20;
  - analog control (base 0xBB): 0xFF.
- R5: A read from any of the three aliases of a register returns that register's current value.
- R6: A write to 0xFD keeps only bit 0 of the data, and a write to 0xFE keeps only bits 2:0. Both read back directly.
- R7: A read of 0xFF returns 0x01 or 0x00. The value is the first of these that applies:
  - bit 0 of 0xFD, if it is set;
  - bit 0 of 0xFE, if it is set;
  - bit 6 of the function control register.
- R8: Addresses 0x00 to 0x03 read 0x51, 0x04, 0x02 and 0xC0, and writes to them have no effect.
- R9: A read or write to an undecoded address pulses err_o high for exactly the cycle after the access. Such a read returns 0x00 and such a write changes no register. Accesses to decoded addresses, including the read-only ones, leave err_o low.
- R10: rdata_o is updated on the clock edge where rd_en_i is high and holds its value otherwise. A read in the same cycle as a write returns the value from before the write.
- R11: After reset the registers hold these values:

  | Register | Reset value |
  |---|---|
  | Function control (0x04) | 0x41 |
  | Interface control (0x07) | 0x10 |
  | State-machine control (0xA1) | 0x10 |
  | Power control (0xAC) | 0x00 |
  | Analog control (0xBB) | 0x00 |
  | Power request (0xFD) | 0x00 |
  | Clock request (0xFE) | 0x02 |

  rdata_o and err_o are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| err_o | output | 1 | One-cycle pulse after an access to an undecoded address |

## Verification
The hardest case to reach from the ports is the status bit falling back to the suspend bit of the function control register. That bit is not writable: it is 1 only from reset and is lost on the first write to that register.

The stimulus therefore reads the status straight after reset, before any write. It then clears the suspend bit through a load of the function control register. After that it raises and drops the power and clock requests in an overlapping order, so that each level of the priority decides the result at least once.

// File: rtl/alias_bank_pkg.sv
`timescale 1ns/1ps
package alias_bank_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  typedef logic [DW-1:0] dbyte_t;
  typedef logic [AW-1:0] addr_t;

  localparam int N_ALIAS = 5;
  localparam addr_t  ALIAS_BASE [N_ALIAS] = '{8'h04, 8'h07, 8'hA1, 8'hAC, 8'hBB};
  localparam dbyte_t ALIAS_MASK [N_ALIAS] = '{8'h80, 8'h61, 8'h3F, 8'h20, 8'hFF};
  localparam dbyte_t ALIAS_RST  [N_ALIAS] = '{8'h41, 8'h10, 8'h10, 8'h00, 8'h00};

  localparam int FUNC_IDX = 0;
  localparam int SUSP_BIT = 6;

  localparam int N_ID = 4;
  localparam addr_t  ID_BASE = 8'h00;
  localparam dbyte_t ID_VAL [N_ID] = '{8'h51, 8'h04, 8'h02, 8'hC0};

  localparam addr_t  PWR_ADDR = 8'hFD;
  localparam addr_t  CLK_ADDR = 8'hFE;
  localparam addr_t  STS_ADDR = 8'hFF;
  localparam dbyte_t PWR_MASK = 8'h01;
  localparam dbyte_t CLK_MASK = 8'h07;
  localparam dbyte_t PWR_RST  = 8'h00;
  localparam dbyte_t CLK_RST  = 8'h02;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } alias_op_e;
endpackage

// File: rtl/alias_reg.sv
`timescale 1ns/1ps
module alias_reg
  import alias_bank_pkg::*;
#(
  parameter addr_t  BASE = 8'h00,
  parameter dbyte_t MASK = 8'hFF,
  parameter dbyte_t RST  = 8'h00
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   wr_en_i,
  input  addr_t  addr_i,
  input  dbyte_t wdata_i,
  output dbyte_t q_o,
  output logic   hit_o
);
  addr_t     off;
  alias_op_e op;
  dbyte_t    nxt;

  assign off = addr_i - BASE;

  always_comb begin
    unique case (off)
      8'd0:    op = OP_LOAD;
      8'd1:    op = OP_SET;
      8'd2:    op = OP_CLR;
      default: op = OP_NONE;
    endcase
  end

  assign hit_o = (op != OP_NONE);

  // mask applied after the operation
  always_comb begin
    unique case (op)
      OP_LOAD: nxt = wdata_i & MASK;
      OP_SET:  nxt = (q_o | wdata_i) & MASK;
      OP_CLR:  nxt = (q_o & ~wdata_i) & MASK;
      default: nxt = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               q_o <= RST;
    else if (wr_en_i && hit_o) q_o <= nxt;
  end
endmodule

// File: rtl/masked_reg.sv
`timescale 1ns/1ps
module masked_reg
  import alias_bank_pkg::*;
#(
  parameter addr_t  ADDR = 8'h00,
  parameter dbyte_t MASK = 8'hFF,
  parameter dbyte_t RST  = 8'h00
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   wr_en_i,
  input  addr_t  addr_i,
  input  dbyte_t wdata_i,
  output dbyte_t q_o,
  output logic   hit_o
);
  assign hit_o = (addr_i == ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               q_o <= RST;
    else if (wr_en_i && hit_o) q_o <= wdata_i & MASK;
  end
endmodule

// File: rtl/id_rom.sv
`timescale 1ns/1ps
module id_rom
  import alias_bank_pkg::*;
(
  input  addr_t  addr_i,
  output dbyte_t data_o,
  output logic   hit_o
);
  logic   [N_ID-1:0] sel;
  dbyte_t            part [N_ID];

  for (genvar g = 0; g < N_ID; g++) begin : g_id
    assign sel[g]  = (addr_i == ID_BASE + addr_t'(g));
    assign part[g] = sel[g] ? ID_VAL[g] : '0;
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < N_ID; i++) data_o |= part[i];
  end

  assign hit_o = |sel;
endmodule

// File: rtl/link_status.sv
`timescale 1ns/1ps
module link_status (
  input  logic pwr_req_i,
  input  logic clk_req_i,
  input  logic susp_i,
  output logic sts_o
);
  always_comb begin
    if (pwr_req_i)      sts_o = 1'b1;
    else if (clk_req_i) sts_o = 1'b1;
    else                sts_o = susp_i;
  end
endmodule

// File: rtl/alias_ctl_bank.sv
`timescale 1ns/1ps
module alias_ctl_bank
  import alias_bank_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [7:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        err_o
);
  dbyte_t             al_q   [N_ALIAS];
  logic [N_ALIAS-1:0] al_hit;
  dbyte_t             pwr_q, clk_q, id_data;
  logic               pwr_hit, clk_hit, id_hit, sts_hit, sts_bit;
  dbyte_t             rd_val;
  logic               known;

  for (genvar g = 0; g < N_ALIAS; g++) begin : g_alias
    alias_reg #(
      .BASE (ALIAS_BASE[g]),
      .MASK (ALIAS_MASK[g]),
      .RST  (ALIAS_RST[g])
    ) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .q_o     (al_q[g]),
      .hit_o   (al_hit[g])
    );
  end

  masked_reg #(.ADDR(PWR_ADDR), .MASK(PWR_MASK), .RST(PWR_RST)) u_pwr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .q_o     (pwr_q),
    .hit_o   (pwr_hit)
  );

  masked_reg #(.ADDR(CLK_ADDR), .MASK(CLK_MASK), .RST(CLK_RST)) u_clk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .q_o     (clk_q),
    .hit_o   (clk_hit)
  );

  id_rom u_id (
    .addr_i (addr_i),
    .data_o (id_data),
    .hit_o  (id_hit)
  );

  link_status u_sts (
    .pwr_req_i (pwr_q[0]),
    .clk_req_i (clk_q[0]),
    .susp_i    (al_q[FUNC_IDX][SUSP_BIT]),
    .sts_o     (sts_bit)
  );

  assign sts_hit = (addr_i == STS_ADDR);

  always_comb begin
    rd_val = '0;
    known  = 1'b0;
    for (int i = 0; i < N_ALIAS; i++) begin
      if (al_hit[i]) begin
        rd_val = al_q[i];
        known  = 1'b1;
      end
    end
    if (id_hit)  begin rd_val = id_data;              known = 1'b1; end
    if (pwr_hit) begin rd_val = pwr_q;                known = 1'b1; end
    if (clk_hit) begin rd_val = clk_q;                known = 1'b1; end
    if (sts_hit) begin rd_val = {{(DW-1){1'b0}}, sts_bit}; known = 1'b1; end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (rd_en_i) rdata_o <= rd_val;
      err_o <= (rd_en_i | wr_en_i) & ~known;
    end
  end
endmodule

// File: rtl/alias_bank_chk.sv
`timescale 1ns/1ps
module alias_bank_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       rd_en_i,
  input logic [7:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       err_o
);
  a_r9_err_on_unknown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past((rd_en_i || wr_en_i) && addr_i == 8'h10) |-> err_o);

  a_r9_err_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(rd_en_i || wr_en_i));

  a_r9_unknown_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && addr_i == 8'h10) |-> rdata_o == 8'h00);

  a_r8_id_first_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && addr_i == 8'h00) |-> rdata_o == 8'h51);

  a_r7_status_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && addr_i == 8'hFF) |-> rdata_o[7:1] == 7'd0);

  a_r6_clk_req_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && addr_i == 8'hFE) |-> rdata_o[7:3] == 5'd0);

  a_r4_power_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en_i && addr_i >= 8'hAC && addr_i <= 8'hAE) |-> (rdata_o & 8'hDF) == 8'h00);

  a_r10_hold_without_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_en_i) |-> $stable(rdata_o));
endmodule

bind alias_ctl_bank alias_bank_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .rd_en_i (rd_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .err_o   (err_o)
);

// File: tb/alias_ctl_bank_tb.sv
`timescale 1ns/1ps
module alias_ctl_bank_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr, rd;
  logic [7:0] addr, wdata;
  logic [7:0] rdata;
  logic       err;

  always #10 clk = ~clk;

  alias_ctl_bank u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_en_i (wr),
    .rd_en_i (rd),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .err_o   (err)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mdl [256];
  logic [7:0] prev_rd;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int base_of(int a);
    int bases[5] = '{'h04, 'h07, 'hA1, 'hAC, 'hBB};
    foreach (bases[i]) if (a >= bases[i] && a <= bases[i] + 2) return bases[i];
    return -1;
  endfunction

  function automatic logic [7:0] mask_of(int b);
    case (b)
      'h04: return 8'h80;
      'h07: return 8'h61;
      'hA1: return 8'h3F;
      'hAC: return 8'h20;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit known(int a);
    return (a <= 3) || (base_of(a) >= 0) || (a >= 'hFD);
  endfunction

  function automatic logic [7:0] exp_read(int a);
    int b = base_of(a);
    if (a <= 3) return mdl[a];
    if (b >= 0) return mdl[b];
    if (a == 'hFD || a == 'hFE) return mdl[a];
    if (a == 'hFF) begin
      if (mdl['hFD][0]) return 8'h01;
      if (mdl['hFE][0]) return 8'h01;
      return {7'd0, mdl['h04][6]};
    end
    return 8'h00;
  endfunction

  task automatic model_write(int a, logic [7:0] d);
    int b = base_of(a);
    logic [7:0] v;
    if (b >= 0) begin
      case (a - b)
        0: v = d;
        1: v = mdl[b] | d;
        default: v = mdl[b] & ~d;
      endcase
      mdl[b] = v & mask_of(b);
    end else if (a == 'hFD) mdl[a] = d & 8'h01;
    else if (a == 'hFE) mdl[a] = d & 8'h07;
  endtask

  task automatic access(bit w, bit r, int a, logic [7:0] d, string req);
    logic [7:0] e_rd;
    logic       e_err;
    @(negedge clk);
    wr = w; rd = r; addr = a[7:0]; wdata = d;
    e_rd  = r ? exp_read(a) : prev_rd;
    e_err = (w || r) && !known(a);
    if (w) model_write(a, d);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    chk(req, rdata, e_rd);
    chk({req, " err"}, {7'd0, err}, {7'd0, e_err});
    prev_rd = e_rd;
  endtask

  task automatic wr_b(int a, logic [7:0] d, string req); access(1, 0, a, d, req); endtask
  task automatic rd_b(int a, string req);                access(0, 1, a, 8'h00, req); endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    mdl[0] = 8'h51; mdl[1] = 8'h04; mdl[2] = 8'h02; mdl[3] = 8'hC0;
    mdl['h04] = 8'h41; mdl['h07] = 8'h10; mdl['hA1] = 8'h10; mdl['hFE] = 8'h02;
    prev_rd = 8'h00;
    wr = 0; rd = 0; addr = 0; wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R11 reset rdata", rdata, 8'h00);
    chk("R11 reset err", {7'd0, err}, 8'h00);

    // reset values and identification
    foreach (mdl[i]) if (i <= 3) rd_b(i, "R8 id read");
    rd_b('h04, "R11 func reset");
    rd_b('h07, "R11 ifc reset");
    rd_b('hA1, "R11 sm reset");
    rd_b('hAC, "R11 power reset");
    rd_b('hBB, "R11 analog reset");
    rd_b('hFD, "R11 pwr req reset");
    rd_b('hFE, "R11 clk req reset");
    rd_b('hFF, "R7 status from suspend bit after reset");

    // load path and mask, aliases
    wr_b('h04, 8'hFF, "R1 load func");
    rd_b('h04, "R4 func mask");
    rd_b('h05, "R5 alias +1 read");
    rd_b('h06, "R5 alias +2 read");
    rd_b('hFF, "R7 status suspend cleared");

    // status priority
    wr_b('hFE, 8'h01, "R6 clk req write");
    rd_b('hFF, "R7 status via clk req");
    wr_b('hFD, 8'hFF, "R6 pwr req write");
    rd_b('hFD, "R6 pwr req mask");
    wr_b('hFE, 8'h00, "R6 clk req drop");
    rd_b('hFF, "R7 status via pwr req");
    wr_b('hFD, 8'h00, "R6 pwr req drop");
    rd_b('hFF, "R7 status falls back");
    wr_b('hFE, 8'hFE, "R6 clk req even");
    rd_b('hFE, "R6 clk req width");
    rd_b('hFF, "R7 clk bit0 clear");

    // set / clear
    wr_b('h08, 8'hFF, "R2 set ifc");
    rd_b('h07, "R2 ifc after set");
    wr_b('h09, 8'h20, "R3 clear ifc");
    rd_b('h09, "R3 ifc after clear");
    wr_b('hA1, 8'hC5, "R1 load sm");
    rd_b('hA1, "R4 sm mask");
    wr_b('hA2, 8'hF0, "R2 set sm");
    rd_b('hA3, "R2 sm after set");
    wr_b('hA3, 8'h01, "R3 clear sm");
    rd_b('hA1, "R3 sm after clear");
    wr_b('hAD, 8'hFF, "R2 set power");
    rd_b('hAC, "R4 power mask");
    wr_b('hAE, 8'hFF, "R3 clear power");
    rd_b('hAD, "R3 power after clear");
    wr_b('hBB, 8'hA5, "R1 load analog");
    wr_b('hBC, 8'h5A, "R2 set analog");
    rd_b('hBB, "R4 analog unmasked");
    wr_b('hBD, 8'h0F, "R3 clear analog");
    rd_b('hBC, "R3 analog after clear");

    // read-only and unknown
    wr_b('h00, 8'hAA, "R8 id write ignored");
    rd_b('h00, "R8 id unchanged");
    wr_b('hFF, 8'hFF, "R8 status write ignored");
    rd_b('hFF, "R7 status unchanged");
    wr_b('h10, 8'h77, "R9 unknown write err");
    rd_b('h10, "R9 unknown read zero");
    wr_b('h0A, 8'hFF, "R9 write past alias range");
    rd_b('h07, "R9 neighbour unchanged");

    // read with write in same cycle, hold
    access(1, 1, 'hBB, 8'h33, "R10 read before write");
    rd_b('hBB, "R10 new value visible");
    access(0, 0, 'h04, 8'h00, "R10 hold without read");
    access(1, 0, 'hA1, 8'h3F, "R10 hold during write");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule